// File: doc/BRIEF.md
# Superpage Promotion Decision Monitor

This block watches the stream of TLB miss events and decides when a run of contiguous virtual pages should be merged into one large page. Base pages are 8 KB, and sixteen neighbouring pages form one 128 KB candidate group. The group key is the virtual page number with its four low bits removed. A small fully associative table follows a parameterised number of candidate groups. Each miss is charged to the group it falls in.

The decision uses the break-even rule from rent-or-buy analysis. Each miss costs one unit. Copying a group into contiguous physical memory costs `copy_cost` units. When a group's charged misses reach that cost, the block asks for promotion. By waiting exactly until the rental spend equals the purchase price, total cost stays within twice the optimum. After promotion the group occupies a single TLB entry, so further misses to it are not charged. The copy and the TLB rewrite belong to the consumer of the request.

An issue state machine offers one request at a time on a valid/ready handshake. It has two states. `S_IDLE` means no request is offered. `S_OFFER` means a request is held on the outputs. The transition *launch* goes from `S_IDLE` to `S_OFFER` when some tracked group has reached its cost. On *launch* the lowest-indexed such entry is captured and marked promoted. The transition *hold* keeps `S_OFFER` while `promo_ready` is low. The transition *retire* returns to `S_IDLE` on the cycle the request is accepted. Misses keep updating the table in every state.

Top module: `spp_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `promo_valid` is 0. Reset empties the tracking table and forgets every promoted group.
- R2: A miss is charged to group `miss_vpn >> 4`, so all sixteen pages of a 128 KB aligned run count together. `promo_base_vpn` carries the group's first page, so its low 4 bits are 0.
- R3: A group becomes ready when its charged miss count reaches `copy_cost`, where a cost of 0 acts as 1. Suppose no request is pending and the threshold miss is sampled at rising edge e. Then `promo_valid` rises at edge e+1.
- R4: While `promo_valid` is 1 and `promo_ready` is 0, `promo_valid` and `promo_base_vpn` stay unchanged. A request is accepted at a rising edge where both are 1. `promo_valid` is 0 in the cycle after acceptance.
- R5: Misses that arrive while a request is pending are still charged to other groups. Groups that became ready meanwhile are offered after acceptance, lowest table entry first.
- R6: Once a group has been offered, misses to it are not charged and never cause a second request until reset. This includes a miss sampled at the same edge as the launch.
- R7: A miss to an untracked group takes the lowest free entry. If no entry is free, the group replaces the tracking entry with the lowest count, with the lowest index winning a tie. Ready and promoted entries are never replaced. The new group starts with a count of 1.
- R8: If no entry is free and no entry is replaceable, a miss to an untracked group is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | One TLB miss this cycle |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| copy_cost | input | CNT_W | Cost to copy a group, in units of one miss |
| promo_valid | output | 1 | Promotion request offered |
| promo_ready | input | 1 | Consumer accepts the offered request |
| promo_base_vpn | output | VPN_W | First virtual page of the group to promote |

## Verification
Two things can happen in the same cycle: the *launch* that marks a group promoted, and a new miss to that same group. Similarly, acceptance of one request can coincide with the miss that charges another group. The bench provokes the first case with an uninterrupted burst of misses to one group that runs past its threshold, so the next miss lands on the launch edge. The run is judged correct only if exactly one request appears. The second case is provoked by holding `promo_ready` low while a second group is driven to its threshold. The bench then checks that both requests arrive in order, with one idle cycle between them.

// File: rtl/spp_pkg.sv
package spp_pkg;

    // Life of one tracking table entry
    typedef enum logic [1:0] {
        E_FREE  = 2'd0,
        E_TRACK = 2'd1,
        E_DONE  = 2'd2
    } ent_state_e;

    // Request issue machine
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } issue_state_e;

endpackage

// File: rtl/spp_lookup.sv
module spp_lookup
    import spp_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int GRP_W   = 16,
    parameter int CNT_W   = 8,
    parameter int IDX_W   = 2
) (
    input  ent_state_e         ent_st   [ENTRIES],
    input  logic [GRP_W-1:0]   ent_grp  [ENTRIES],
    input  logic [CNT_W-1:0]   ent_cnt  [ENTRIES],
    input  logic [GRP_W-1:0]   miss_grp,
    input  logic [CNT_W-1:0]   copy_cost,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic               vict_any,
    output logic [IDX_W-1:0]   vict_idx,
    output logic               ready_any,
    output logic [IDX_W-1:0]   ready_idx
);

    logic [CNT_W-1:0]   thr;
    logic [ENTRIES-1:0] ready_vec;
    logic [CNT_W-1:0]   best;

    // a zero cost behaves as a cost of one
    assign thr = (copy_cost == '0) ? CNT_W'(1) : copy_cost;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ready
        assign ready_vec[g] = (ent_st[g] == E_TRACK) && (ent_cnt[g] >= thr);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_vec   = '0;
        hit_idx   = '0;
        free_any  = 1'b0;
        free_idx  = '0;
        vict_any  = 1'b0;
        vict_idx  = '0;
        best      = '0;
        ready_any = 1'b0;
        ready_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_st[i] != E_FREE && ent_grp[i] == miss_grp) begin
                hit_vec[i] = 1'b1;
                hit_idx    = IDX_W'(i);
            end
            if (ent_st[i] == E_FREE && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (ready_vec[i] && !ready_any) begin
                ready_any = 1'b1;
                ready_idx = IDX_W'(i);
            end
            // strict compare keeps the lowest index on a tie
            if (ent_st[i] == E_TRACK && !ready_vec[i] &&
                (!vict_any || ent_cnt[i] < best)) begin
                vict_any = 1'b1;
                vict_idx = IDX_W'(i);
                best     = ent_cnt[i];
            end
        end
    end

endmodule

// File: rtl/spp_issue.sv
module spp_issue
    import spp_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int GRP_SHIFT = 4,
    parameter int GRP_W     = 16,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_any,
    input  logic [IDX_W-1:0] ready_idx,
    input  logic [GRP_W-1:0] ready_grp,
    input  logic             promo_ready,
    output logic             launch,
    output logic [IDX_W-1:0] launch_idx,
    output logic             promo_valid,
    output logic [VPN_W-1:0] promo_base_vpn
);

    issue_state_e st_q, st_d;
    logic [VPN_W-1:0] base_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions: launch, hold, retire
    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (ready_any) begin
                    st_d   = S_OFFER;
                    launch = 1'b1;
                end
            end
            S_OFFER: begin
                if (promo_ready) st_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (launch) base_q <= {ready_grp, {GRP_SHIFT{1'b0}}};
    end

    assign launch_idx     = ready_idx;
    assign promo_valid    = (st_q == S_OFFER);
    assign promo_base_vpn = base_q;

endmodule

// File: rtl/spp_monitor.sv
module spp_monitor
    import spp_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int GRP_SHIFT = 4,
    parameter int ENTRIES   = 4,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [CNT_W-1:0] copy_cost,
    output logic             promo_valid,
    input  logic             promo_ready,
    output logic [VPN_W-1:0] promo_base_vpn
);

    localparam int GRP_W = VPN_W - GRP_SHIFT;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ent_state_e         ent_st  [ENTRIES];
    logic [GRP_W-1:0]   ent_grp [ENTRIES];
    logic [CNT_W-1:0]   ent_cnt [ENTRIES];

    logic [GRP_W-1:0]   miss_grp;
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any, free_any, vict_any, ready_any, launch;
    logic [IDX_W-1:0]   hit_idx, free_idx, vict_idx, ready_idx, launch_idx;
    logic [GRP_W-1:0]   hit_grp, ready_grp;

    assign miss_grp  = GRP_W'(miss_vpn >> GRP_SHIFT);
    assign hit_grp   = ent_grp[hit_idx];
    assign ready_grp = ent_grp[ready_idx];

    spp_lookup #(
        .ENTRIES (ENTRIES), .GRP_W (GRP_W), .CNT_W (CNT_W), .IDX_W (IDX_W)
    ) u_lookup (
        .ent_st    (ent_st),
        .ent_grp   (ent_grp),
        .ent_cnt   (ent_cnt),
        .miss_grp  (miss_grp),
        .copy_cost (copy_cost),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .vict_any  (vict_any),
        .vict_idx  (vict_idx),
        .ready_any (ready_any),
        .ready_idx (ready_idx)
    );

    spp_issue #(
        .VPN_W (VPN_W), .GRP_SHIFT (GRP_SHIFT), .GRP_W (GRP_W), .IDX_W (IDX_W)
    ) u_issue (
        .clk            (clk),
        .rst_n          (rst_n),
        .ready_any      (ready_any),
        .ready_idx      (ready_idx),
        .ready_grp      (ready_grp),
        .promo_ready    (promo_ready),
        .launch         (launch),
        .launch_idx     (launch_idx),
        .promo_valid    (promo_valid),
        .promo_base_vpn (promo_base_vpn)
    );

    // tracking table: charge, allocate, replace, retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_st[i]  <= E_FREE;
                ent_grp[i] <= '0;
                ent_cnt[i] <= '0;
            end
        end else begin
            if (miss_valid) begin
                if (hit_any) begin
                    if (ent_st[hit_idx] == E_TRACK && ent_cnt[hit_idx] != CNT_MAX)
                        ent_cnt[hit_idx] <= ent_cnt[hit_idx] + 1'b1;
                end else if (free_any) begin
                    ent_st[free_idx]  <= E_TRACK;
                    ent_grp[free_idx] <= miss_grp;
                    ent_cnt[free_idx] <= CNT_W'(1);
                end else if (vict_any) begin
                    ent_grp[vict_idx] <= miss_grp;
                    ent_cnt[vict_idx] <= CNT_W'(1);
                end
            end
            // launch wins over a same-cycle charge to its own entry
            if (launch) begin
                ent_st[launch_idx]  <= E_DONE;
                ent_cnt[launch_idx] <= '0;
            end
        end
    end

endmodule

// File: rtl/spp_monitor_chk.sv
module spp_monitor_chk #(
    parameter int VPN_W     = 20,
    parameter int GRP_SHIFT = 4,
    parameter int ENTRIES   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     miss_valid,
    input logic [VPN_W-1:0]         miss_vpn,
    input logic                     promo_valid,
    input logic                     promo_ready,
    input logic [VPN_W-1:0]         promo_base_vpn,
    input logic [ENTRIES-1:0]       hit_vec,
    input logic                     hit_any,
    input logic [VPN_W-GRP_SHIFT-1:0] hit_grp
);

    localparam int GRP_W = VPN_W - GRP_SHIFT;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !promo_valid);

    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> (promo_base_vpn[GRP_SHIFT-1:0] == '0));

    assert_hit_matches_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && hit_any) |-> (hit_grp == GRP_W'(miss_vpn >> GRP_SHIFT)));

    assert_request_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_valid && !promo_ready) |=> (promo_valid && $stable(promo_base_vpn)));

    assert_gap_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_valid && promo_ready) |=> !promo_valid);

    assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind spp_monitor spp_monitor_chk #(
    .VPN_W (VPN_W), .GRP_SHIFT (GRP_SHIFT), .ENTRIES (ENTRIES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_vpn       (miss_vpn),
    .promo_valid    (promo_valid),
    .promo_ready    (promo_ready),
    .promo_base_vpn (promo_base_vpn),
    .hit_vec        (hit_vec),
    .hit_any        (hit_any),
    .hit_grp        (hit_grp)
);

// File: tb/spp_monitor_test.sv
module spp_monitor_test;

    localparam int VPN_W = 20;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             miss_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic [CNT_W-1:0] copy_cost = 8'd4;
    logic             promo_valid;
    logic             promo_ready = 1'b1;
    logic [VPN_W-1:0] promo_base_vpn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [VPN_W-1:0] exp_q [$];
    string            tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    spp_monitor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_vpn       (miss_vpn),
        .copy_cost      (copy_cost),
        .promo_valid    (promo_valid),
        .promo_ready    (promo_ready),
        .promo_base_vpn (promo_base_vpn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares every accepted request
    always @(negedge clk) begin
        if (rst_n && promo_valid && promo_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected request", 32'(promo_base_vpn), 32'hFFFF_FFFF);
            end else begin
                automatic logic [VPN_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(promo_base_vpn == e, t, "request base", 32'(promo_base_vpn), 32'(e));
            end
        end
    end

    task automatic expect_req(input logic [VPN_W-1:0] base, input string req);
        exp_q.push_back(base);
        tag_q.push_back(req);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; miss_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic miss(input logic [VPN_W-1:0] v);
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_vpn = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            miss_valid = 1'b0;
        end
    endtask

    task automatic drained(input string req);
        idle(10);
        chk(exp_q.size() == 0, req, "pending expected requests", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(promo_valid == 1'b0, "R1", "valid in reset", 32'(promo_valid), 32'd0);
        do_reset();
        @(negedge clk);
        chk(promo_valid == 1'b0, "R1", "valid after reset", 32'(promo_valid), 32'd0);

        // R3: three misses below cost 4 give nothing
        for (int k = 0; k < 3; k++) miss(20'h0A000 + 20'(k));
        drained("R3");

        // R2, R3: four pages of one group, latency check
        do_reset();
        expect_req(20'h12340, "R2");
        miss(20'h12340); miss(20'h1234F); miss(20'h12347); miss(20'h12341);
        idle(1);
        @(negedge clk);
        chk(promo_valid == 1'b0, "R3", "valid one edge after threshold", 32'(promo_valid), 32'd0);
        @(negedge clk);
        chk(promo_valid == 1'b1, "R3", "valid two edges after threshold", 32'(promo_valid), 32'd1);
        drained("R2");

        // R6: promoted group ignored, and burst hitting the launch edge
        for (int k = 0; k < 5; k++) miss(20'h12345);
        drained("R6");
        expect_req(20'h55550, "R6");
        for (int k = 0; k < 6; k++) miss(20'h55550 + 20'(k));
        drained("R6");

        // R4, R5: hold while not accepted, other group charged meanwhile
        do_reset();
        promo_ready = 1'b0;
        expect_req(20'h2AA00, "R4");
        expect_req(20'h3BB00, "R5");
        for (int k = 0; k < 4; k++) miss(20'h2AA00 + 20'(k));
        idle(2);
        for (int k = 0; k < 4; k++) miss(20'h3BB0F);
        idle(3);
        @(negedge clk);
        chk(promo_valid == 1'b1, "R4", "valid held", 32'(promo_valid), 32'd1);
        chk(promo_base_vpn == 20'h2AA00, "R4", "base held", 32'(promo_base_vpn), 32'h2AA00);
        @(posedge clk); #1 promo_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(promo_valid == 1'b0, "R4", "gap after accept", 32'(promo_valid), 32'd0);
        drained("R5");

        // R7: replacement of the lowest-count entry
        do_reset();
        for (int k = 0; k < 3; k++) miss(20'h40000);
        miss(20'h40010);
        for (int k = 0; k < 2; k++) miss(20'h40020);
        for (int k = 0; k < 3; k++) miss(20'h40030);
        miss(20'h40040);                 // evicts group at 0x40010
        for (int k = 0; k < 3; k++) miss(20'h40010);
        drained("R7");                   // restarted count is 3, below cost
        expect_req(20'h40010, "R7");
        miss(20'h40010);
        drained("R7");
        expect_req(20'h40000, "R7");
        miss(20'h40000);                 // kept entry reaches cost
        drained("R7");

        // R3: cost of zero acts as one, larger cost
        do_reset();
        copy_cost = 8'd0;
        expect_req(20'h77770, "R3");
        miss(20'h7777C);
        drained("R3");
        do_reset();
        copy_cost = 8'd7;
        for (int k = 0; k < 6; k++) miss(20'h60000);
        drained("R3");
        expect_req(20'h60000, "R3");
        miss(20'h60009);
        drained("R3");

        // R8: full table of promoted entries drops new groups
        do_reset();
        copy_cost = 8'd1;
        for (int k = 0; k < 4; k++) expect_req(20'h50000 + 20'(k * 16), "R8");
        for (int k = 0; k < 4; k++) miss(20'h50000 + 20'(k * 16));
        drained("R8");
        for (int k = 0; k < 3; k++) miss(20'h59990);
        miss(20'h50000);
        drained("R8");
        // R1: reset forgets promoted groups
        do_reset();
        expect_req(20'h50000, "R1");
        miss(20'h50003);
        drained("R1");

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule